// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

This block is a synthesizable model of a synchronous SRAM with a shared data bus, built so that reads and writes can be issued on consecutive clocks with no idle cycles between them. A read returns its data from an output register one clock after the address is taken. A write takes its data two clocks after its address. The bus can therefore be handed from the SRAM to the host and back without a gap. The bidirectional bus is split into a data-in port, a data-out port and a drive-enable flag. The drive-enable combines the pipelined read state with an asynchronous output-enable pin.

An on-chip two-bit beat counter supports bursts of up to four accesses from one loaded address. A pin selects linear or interleaved beat order. The access type is fixed when the burst is loaded. Byte-select lines mask individual bytes on a write. A clock-enable pin freezes the whole pipeline. Three chip enables, one of them active-high, select the device. Deselecting it is pipelined like any other access.

Top module: `zt_sram`

## Requirements
- R1: After reset `dq_oe` is 0, and no access is pending in the pipeline.
- R2: An access starts at a rising edge when `cen_n`=0, `adv_ld_n`=0, `ce1_n`=0, `ce2`=1 and `ce3_n`=0. `we_n`=1 makes it a read and `we_n`=0 makes it a write.
- R3: For a read whose address is taken at edge N, `dout` holds the word after edge N+1. `dq_oe` is 1 from then on while `oe_n` is 0.
- R4: For a write whose address is taken at edge N, `din` is captured at edge N+2. `dq_oe` is 0 after edge N+1 whatever the level of `oe_n`.
- R5: If `adv_ld_n`=0 at edge N and any chip enable is inactive, no access starts and `dq_oe` is 0 after edge N+1.
- R6: A read issued on the edge right after a write to the same address returns the newly written bytes merged with the old ones. This holds even though the write data is captured on the same edge as the read.
- R7: On a write, `bw_n[i]`=0 updates byte i (bits 8i+7..8i) and `bw_n[i]`=1 leaves that byte unchanged.
- R8: `adv_ld_n`=1 during an active burst issues the next beat whatever the levels of the chip enables and `we_n`. Every beat keeps the read/write type captured at load. The beat index is 2 bits and wraps.
- R9: When `mode`=0, beat k uses address low bits (start+k) mod 4. When `mode`=1, beat k uses start XOR k. Upper address bits stay fixed.
- R10: While `cen_n`=1 the clock edge is ignored. `dout`, the drive state, the pipeline, the burst state and the array all hold, and the other inputs have no effect.
- R11: `adv_ld_n`=1 with no active burst, for example after a deselect, starts no access.
- R12: `oe_n`=1 forces `dq_oe` to 0 at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of pipeline and burst state |
| cen_n | input | 1 | Clock enable, active low; high stalls every register |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| adv_ld_n | input | 1 | Low loads a new address, high advances the burst |
| we_n | input | 1 | Write enable, active low, sampled at load |
| mode | input | 1 | Burst order: 0 linear, 1 interleaved |
| oe_n | input | 1 | Asynchronous output enable, active low |
| addr | input | ADDR_W | Word address |
| bw_n | input | NBYTES | Byte write selects, active low, taken with each write beat |
| din | input | NBYTES*BYTE_W | Write data, bus input side |
| dout | output | NBYTES*BYTE_W | Read data from the output register |
| dq_oe | output | 1 | High when the block drives the bus |

## Verification
The hardest situation to reach is a read that lands on the edge where an earlier write to the same word is still only partly applied. The bench gets there by loading a byte-masked write and then, on the very next clock, loading a read of the same address. The second write data value then arrives on the same edge as the read and must be merged into the returned word. Bursts are checked by writing four beats in linear order and reading them back in interleaved order from a start address whose low bits differ between the two orders. During those beats the chip enables and `we_n` are toggled to show they are ignored. A stall is placed while a read is in flight and another while read data is being driven.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;

   typedef enum logic {
      ORDER_LINEAR      = 1'b0,
      ORDER_INTERLEAVED = 1'b1
   } beat_order_e;

   // chip enable pattern {ce1_n, ce2, ce3_n} that selects the device
   localparam logic [2:0] SELECT_PATTERN = 3'b010;

endpackage

// File: rtl/zt_burst_seq.sv
module zt_burst_seq
   import zt_sram_pkg::*;
#(
   parameter int ADDR_W        = 6,
   parameter int BEAT_W        = 2,
   parameter bit INTERLEAVE_EN = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              adv_en,
   input  logic              load,
   input  logic              step,
   input  logic              wr_in,
   input  logic              mode,
   input  logic [ADDR_W-1:0] addr_in,
   output logic              issue_vld,
   output logic              issue_wr,
   output logic [ADDR_W-1:0] issue_addr
);

   localparam int HI_W = ADDR_W - BEAT_W;

   initial begin
      assert (BEAT_W >= 1) else $error("BEAT_W must be at least 1");
      assert (ADDR_W > BEAT_W) else $error("ADDR_W must exceed BEAT_W");
   end

   logic [ADDR_W-1:0] base_q;
   logic [BEAT_W-1:0] beat_q;
   logic              wr_q;
   logic              act_q;

   logic [BEAT_W-1:0] nxt_beat;
   logic [BEAT_W-1:0] low_lin;
   logic [BEAT_W-1:0] low_sel;

   assign nxt_beat = beat_q + 1'b1;
   assign low_lin  = base_q[BEAT_W-1:0] + nxt_beat;

   generate
      if (INTERLEAVE_EN) begin : g_both_orders
         logic [BEAT_W-1:0] low_xor;
         assign low_xor = base_q[BEAT_W-1:0] ^ nxt_beat;
         assign low_sel = (beat_order_e'(mode) == ORDER_INTERLEAVED) ? low_xor : low_lin;
      end else begin : g_linear_only
         assign low_sel = low_lin;
      end
   endgenerate

   always_comb begin
      issue_vld  = 1'b0;
      issue_wr   = 1'b0;
      issue_addr = addr_in;
      if (load) begin
         issue_vld  = 1'b1;
         issue_wr   = wr_in;
         issue_addr = addr_in;
      end else if (step && act_q) begin
         issue_vld  = 1'b1;
         issue_wr   = wr_q;
         issue_addr = {base_q[ADDR_W-1:BEAT_W], low_sel};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         beat_q <= '0;
         wr_q   <= 1'b0;
         act_q  <= 1'b0;
      end else if (adv_en) begin
         if (load) begin
            base_q <= addr_in;
            beat_q <= '0;
            wr_q   <= wr_in;
            act_q  <= 1'b1;
         end else if (step && act_q) begin
            beat_q <= nxt_beat;
         end else if (!step) begin
            act_q  <= 1'b0;
         end
      end
   end

   // R8
   beat_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_en && step && act_q) |=> (beat_q == $past(beat_q) + 1'b1) && act_q);

   // R11
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_en && step && !act_q) |=> !act_q);

   // R10
   stall_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !adv_en |=> $stable(beat_q) && $stable(act_q) && $stable(base_q));

   HI_W_unused_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_en && step && act_q && HI_W > 0) |-> issue_addr[ADDR_W-1:BEAT_W] == base_q[ADDR_W-1:BEAT_W]);

endmodule

// File: rtl/zt_byte_ram.sv
module zt_byte_ram #(
   parameter int ADDR_W = 6,
   parameter int NBYTES = 4,
   parameter int BYTE_W = 8
)(
   input  logic                     clk,
   input  logic                     we,
   input  logic [ADDR_W-1:0]        waddr,
   input  logic [NBYTES-1:0]        wbe_n,
   input  logic [NBYTES*BYTE_W-1:0] wdata,
   input  logic [ADDR_W-1:0]        raddr,
   output logic [NBYTES*BYTE_W-1:0] rdata
);

   localparam int DEPTH = 1 << ADDR_W;

   initial begin
      assert (DEPTH <= 1024) else $error("array kept small: ADDR_W at most 10");
      assert (NBYTES >= 1 && BYTE_W >= 1) else $error("byte geometry invalid");
   end

   logic hit;
   assign hit = we && (waddr == raddr);

   generate
      for (genvar b = 0; b < NBYTES; b++) begin : g_lane
         logic [BYTE_W-1:0] lane_mem [DEPTH];
         logic              lane_wr;

         assign lane_wr = we && !wbe_n[b];

         always_ff @(posedge clk) begin
            if (lane_wr) lane_mem[waddr] <= wdata[b*BYTE_W +: BYTE_W];
         end

         // same-edge write data is forwarded to the reader lane by lane
         assign rdata[b*BYTE_W +: BYTE_W] = (hit && !wbe_n[b]) ?
                                            wdata[b*BYTE_W +: BYTE_W] : lane_mem[raddr];
      end
   endgenerate

endmodule

// File: rtl/zt_sram.sv
module zt_sram
   import zt_sram_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int NBYTES = 4,
   parameter int BYTE_W = 8,
   parameter bit INTERLEAVE_EN = 1'b1
)(
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cen_n,
   input  logic                     ce1_n,
   input  logic                     ce2,
   input  logic                     ce3_n,
   input  logic                     adv_ld_n,
   input  logic                     we_n,
   input  logic                     mode,
   input  logic                     oe_n,
   input  logic [ADDR_W-1:0]        addr,
   input  logic [NBYTES-1:0]        bw_n,
   input  logic [NBYTES*BYTE_W-1:0] din,
   output logic [NBYTES*BYTE_W-1:0] dout,
   output logic                     dq_oe
);

   localparam int DW     = NBYTES * BYTE_W;
   localparam int BEAT_W = 2;

   initial begin
      assert (DW <= 256) else $error("data width too large");
   end

   logic adv_en;
   logic sel;
   logic load;

   assign adv_en = !cen_n;
   assign sel    = ({ce1_n, ce2, ce3_n} == SELECT_PATTERN);
   assign load   = !adv_ld_n && sel;

   logic              iss_vld;
   logic              iss_wr;
   logic [ADDR_W-1:0] iss_addr;

   zt_burst_seq #(
      .ADDR_W       (ADDR_W),
      .BEAT_W       (BEAT_W),
      .INTERLEAVE_EN(INTERLEAVE_EN)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .adv_en    (adv_en),
      .load      (load),
      .step      (adv_ld_n),
      .wr_in     (!we_n),
      .mode      (mode),
      .addr_in   (addr),
      .issue_vld (iss_vld),
      .issue_wr  (iss_wr),
      .issue_addr(iss_addr)
   );

   // stage 1: access issued at the last enabled edge
   logic              s1_vld, s1_wr;
   logic [ADDR_W-1:0] s1_addr;
   logic [NBYTES-1:0] s1_bw_n;
   // stage 2: write waiting for its data
   logic              s2_wr;
   logic [ADDR_W-1:0] s2_addr;
   logic [NBYTES-1:0] s2_bw_n;
   // output register
   logic [DW-1:0]     rd_q;
   logic              drv_q;

   logic [DW-1:0]     ram_rdata;
   logic              ram_we;
   logic              s1_rd;

   assign ram_we = adv_en && s2_wr;
   assign s1_rd  = s1_vld && !s1_wr;

   zt_byte_ram #(
      .ADDR_W(ADDR_W),
      .NBYTES(NBYTES),
      .BYTE_W(BYTE_W)
   ) u_ram (
      .clk  (clk),
      .we   (ram_we),
      .waddr(s2_addr),
      .wbe_n(s2_bw_n),
      .wdata(din),
      .raddr(s1_addr),
      .rdata(ram_rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_vld  <= 1'b0;
         s1_wr   <= 1'b0;
         s1_addr <= '0;
         s1_bw_n <= '1;
         s2_wr   <= 1'b0;
         s2_addr <= '0;
         s2_bw_n <= '1;
         rd_q    <= '0;
         drv_q   <= 1'b0;
      end else if (adv_en) begin
         s1_vld  <= iss_vld;
         s1_wr   <= iss_wr;
         s1_addr <= iss_addr;
         s1_bw_n <= bw_n;
         s2_wr   <= s1_vld && s1_wr;
         s2_addr <= s1_addr;
         s2_bw_n <= s1_bw_n;
         drv_q   <= s1_rd;
         if (s1_rd) rd_q <= ram_rdata;
      end
   end

   assign dout  = rd_q;
   assign dq_oe = drv_q && !oe_n;

   // R10
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cen_n |=> $stable(rd_q) && $stable(drv_q) && $stable(s1_vld) && $stable(s2_wr));

   // R4
   write_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_en && s1_vld && s1_wr) |=> !dq_oe);

   // R5
   deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_en && !adv_ld_n && !sel) |=> !s1_vld);

   // R3
   read_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_en && s1_rd) |=> drv_q);

   // R1
   reset_idle_chk: assert property (@(posedge clk)
      !rst_n |-> !dq_oe);

endmodule

// File: tb/zt_sram_bench.sv
module zt_sram_bench;

   localparam int AW = 6;
   localparam int NB = 4;
   localparam int DW = 32;

   typedef struct packed {
      logic          cen_n;
      logic [2:0]    ce;     // {ce1_n, ce2, ce3_n}
      logic          adv_n;
      logic          we_n;
      logic          mode;
      logic [AW-1:0] a;
      logic [NB-1:0] bw_n;
      logic [DW-1:0] d;
      logic          eoe;
      logic [DW-1:0] edq;
      logic [7:0]    req;
   } vec_t;

   localparam logic [2:0] SL = 3'b010; // selected
   localparam logic [2:0] N3 = 3'b011; // ce3_n inactive
   localparam logic [2:0] N2 = 3'b000; // ce2 inactive
   localparam int NV = 26;

   localparam vec_t TBL [NV] = '{
      '{1'b0, SL, 1'b0, 1'b0, 1'b0, 6'h04, 4'h0, 32'h0,        1'b0, 32'h0,        8'd2 },  // 0  R2 write 04
      '{1'b0, SL, 1'b0, 1'b0, 1'b0, 6'h05, 4'h0, 32'h0,        1'b0, 32'h0,        8'd4 },  // 1  R4 write 05
      '{1'b0, SL, 1'b0, 1'b1, 1'b0, 6'h04, 4'h0, 32'h11111111, 1'b0, 32'h0,        8'd4 },  // 2  R4 read 04, data of 04
      '{1'b0, SL, 1'b0, 1'b1, 1'b0, 6'h05, 4'h0, 32'h22222222, 1'b1, 32'h11111111, 8'd3 },  // 3  R3
      '{1'b0, N3, 1'b0, 1'b1, 1'b0, 6'h00, 4'h0, 32'h0,        1'b1, 32'h22222222, 8'd3 },  // 4  R3 deselect issued
      '{1'b0, SL, 1'b1, 1'b1, 1'b0, 6'h00, 4'h0, 32'h0,        1'b0, 32'h0,        8'd5 },  // 5  R5 adv while idle
      '{1'b0, SL, 1'b1, 1'b0, 1'b0, 6'h00, 4'h0, 32'h0,        1'b0, 32'h0,        8'd11},  // 6  R11
      '{1'b0, SL, 1'b0, 1'b0, 1'b0, 6'h09, 4'h0, 32'h0,        1'b0, 32'h0,        8'd11},  // 7  R11; burst write 09
      '{1'b0, SL, 1'b1, 1'b1, 1'b0, 6'h3F, 4'h0, 32'h0,        1'b0, 32'h0,        8'd8 },  // 8  R8 we_n ignored
      '{1'b0, N2, 1'b1, 1'b1, 1'b0, 6'h3F, 4'h0, 32'hA0A0A0A0, 1'b0, 32'h0,        8'd8 },  // 9  R8 ce ignored
      '{1'b0, SL, 1'b1, 1'b1, 1'b0, 6'h00, 4'h0, 32'hB0B0B0B0, 1'b0, 32'h0,        8'd9 },  // 10 R9 linear
      '{1'b0, SL, 1'b0, 1'b1, 1'b1, 6'h09, 4'h0, 32'hC0C0C0C0, 1'b0, 32'h0,        8'd4 },  // 11 R4 burst read 09
      '{1'b0, SL, 1'b1, 1'b0, 1'b1, 6'h00, 4'h0, 32'hD0D0D0D0, 1'b1, 32'hA0A0A0A0, 8'd9 },  // 12 R9 beat0
      '{1'b0, N2, 1'b1, 1'b0, 1'b1, 6'h00, 4'h0, 32'h0,        1'b1, 32'hD0D0D0D0, 8'd9 },  // 13 R9 beat1 -> 08
      '{1'b0, SL, 1'b1, 1'b0, 1'b1, 6'h00, 4'h0, 32'h0,        1'b1, 32'hC0C0C0C0, 8'd9 },  // 14 R9 beat2 -> 0B
      '{1'b0, N3, 1'b0, 1'b1, 1'b0, 6'h00, 4'h0, 32'h0,        1'b1, 32'hB0B0B0B0, 8'd8 },  // 15 R8 beat3 -> 0A
      '{1'b0, SL, 1'b0, 1'b0, 1'b0, 6'h04, 4'hA, 32'h0,        1'b0, 32'h0,        8'd5 },  // 16 R5; byte write 04
      '{1'b0, SL, 1'b0, 1'b1, 1'b0, 6'h04, 4'h0, 32'h0,        1'b0, 32'h0,        8'd4 },  // 17 R4 read 04 at once
      '{1'b0, N3, 1'b0, 1'b1, 1'b0, 6'h00, 4'h0, 32'h55667788, 1'b1, 32'h11661188, 8'd6 },  // 18 R6 R7 forwarded merge
      '{1'b0, N2, 1'b0, 1'b1, 1'b0, 6'h00, 4'h0, 32'h0,        1'b0, 32'h0,        8'd5 },  // 19 R5
      '{1'b0, SL, 1'b0, 1'b1, 1'b0, 6'h05, 4'h0, 32'h0,        1'b0, 32'h0,        8'd5 },  // 20 read 05
      '{1'b1, SL, 1'b0, 1'b1, 1'b0, 6'h04, 4'h0, 32'h0,        1'b0, 32'h0,        8'd10},  // 21 R10 stall, load ignored
      '{1'b1, SL, 1'b0, 1'b0, 1'b0, 6'h04, 4'h0, 32'h0,        1'b0, 32'h0,        8'd10},  // 22 R10
      '{1'b0, N3, 1'b0, 1'b1, 1'b0, 6'h00, 4'h0, 32'h0,        1'b1, 32'h22222222, 8'd10},  // 23 R10 read 05 resumes
      '{1'b1, N3, 1'b0, 1'b1, 1'b0, 6'h00, 4'h0, 32'h0,        1'b1, 32'h22222222, 8'd10},  // 24 R10 output held
      '{1'b0, N3, 1'b0, 1'b1, 1'b0, 6'h00, 4'h0, 32'h0,        1'b0, 32'h0,        8'd5 }   // 25 R5
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cen_n = 1'b0;
   logic          ce1_n = 1'b1;
   logic          ce2 = 1'b0;
   logic          ce3_n = 1'b1;
   logic          adv_ld_n = 1'b0;
   logic          we_n = 1'b1;
   logic          mode = 1'b0;
   logic          oe_n = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [NB-1:0] bw_n = '1;
   logic [DW-1:0] din = '0;
   logic [DW-1:0] dout;
   logic          dq_oe;

   int n_run = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   zt_sram u_zt_sram (
      .clk(clk), .rst_n(rst_n), .cen_n(cen_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
      .adv_ld_n(adv_ld_n), .we_n(we_n), .mode(mode), .oe_n(oe_n), .addr(addr),
      .bw_n(bw_n), .din(din), .dout(dout), .dq_oe(dq_oe)
   );

   task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic apply(input vec_t v);
      cen_n    = v.cen_n;
      {ce1_n, ce2, ce3_n} = v.ce;
      adv_ld_n = v.adv_n;
      we_n     = v.we_n;
      mode     = v.mode;
      addr     = v.a;
      bw_n     = v.bw_n;
      din      = v.d;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #2;
      check("R1 dq_oe in reset", {31'b0, dq_oe}, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #2;
      check("R1 dq_oe after reset", {31'b0, dq_oe}, 32'h0);

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         apply(TBL[i]);
         @(posedge clk);
         #2;
         check($sformatf("R%0d step %0d dq_oe", TBL[i].req, i), {31'b0, dq_oe}, {31'b0, TBL[i].eoe});
         if (TBL[i].eoe)
            check($sformatf("R%0d step %0d dout", TBL[i].req, i), dout, TBL[i].edq);
      end

      // R12: output enable acts without a clock edge
      @(negedge clk);
      apply('{1'b0, SL, 1'b0, 1'b1, 1'b0, 6'h09, 4'h0, 32'h0, 1'b0, 32'h0, 8'd0});
      @(negedge clk);
      apply('{1'b0, N3, 1'b0, 1'b1, 1'b0, 6'h00, 4'h0, 32'h0, 1'b0, 32'h0, 8'd0});
      @(posedge clk);
      #2;
      check("R12 driven with oe_n low", {31'b0, dq_oe}, 32'h1);
      check("R3 read 09", dout, 32'hA0A0A0A0);
      oe_n = 1'b1;
      #1;
      check("R12 oe_n high releases bus", {31'b0, dq_oe}, 32'h0);
      oe_n = 1'b0;
      #1;
      check("R12 oe_n low drives again", {31'b0, dq_oe}, 32'h1);

      // R7: byte 3 only, then read back
      @(negedge clk);
      apply('{1'b0, SL, 1'b0, 1'b0, 1'b0, 6'h05, 4'h7, 32'h0, 1'b0, 32'h0, 8'd0});
      @(negedge clk);
      apply('{1'b0, N3, 1'b0, 1'b1, 1'b0, 6'h00, 4'h0, 32'h0, 1'b0, 32'h0, 8'd0});
      @(negedge clk);
      apply('{1'b0, SL, 1'b0, 1'b1, 1'b0, 6'h05, 4'h0, 32'h9ABCDEF0, 1'b0, 32'h0, 8'd0});
      @(negedge clk);
      apply('{1'b0, N3, 1'b0, 1'b1, 1'b0, 6'h00, 4'h0, 32'h0, 1'b0, 32'h0, 8'd0});
      @(posedge clk);
      #2;
      check("R7 only byte 3 written", dout, 32'h9A222222);

      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (2000) @(posedge clk);
      if (!finished) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule